// File: doc/BRIEF.md
# Pulse Rate Divider

The block takes an asynchronous pulse stream and produces one output pulse, one system clock wide, for every N rising transitions that arrive on its input. N is fixed when the design is elaborated. The input is first brought into the clock domain by a two-flop synchroniser. A third register then turns each rising transition into a single-cycle step strobe that advances a terminal counter.

Four counting styles are available through a parameter. All four give the same output sequence, so the choice only affects area and logic depth:
- up-counting with an equality compare;
- down-counting with a compare against zero;
- down-counting with an extra sign bit that flags the terminal count;
- up-counting from a preload, where the carry-out flags the terminal count.

The counter width k is the ceiling of log2(N+1). Elaboration stops if N is below 2 or if the style value is unknown.

Top module: `pulse_rate_div`

## Requirements
- R1: A rising transition of `pin_in` that is set up before clock edge E counts as a step at edge E+2. If that step completes a group of N, `pulse_out` is high during the cycle that follows edge E+2.
- R2: `pulse_out` is never high for two consecutive clock cycles.
- R3: `pulse_out` fires once for every N counted rising transitions. After reset is released, the first pulse follows exactly the N-th rising transition.
- R4: Style 0 (up-compare) starts at 0, adds one per step, and on reaching N returns to 0 and fires.
- R5: Style 1 (down-compare) starts at N, subtracts one per step, and on reaching 0 reloads N and fires.
- R6: Style 2 (sign-bit) uses a counter k+1 bits wide that starts at N−1 and subtracts one per step. When its top bit turns to 1, it reloads N−1 and fires.
- R7: Style 3 (carry) uses a k-bit counter that starts at 2^k−N and adds one per step. A carry-out from the all-ones value reloads 2^k−N and fires.
- R8: For the same N and the same input waveform, all four styles produce identical `pulse_out` sequences, cycle for cycle.
- R9: While `rst` is high at a rising clock edge, the synchroniser, the counter and the output are returned to their initial values, and `pulse_out` is low in the following cycle.
- R10: Only rising transitions are counted. A high level held for many cycles counts once, and falling transitions have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_in | input | 1 | Asynchronous pulse input to be divided |
| pulse_out | output | 1 | One-cycle pulse for every N rising transitions on the input |

## Verification
The bench runs N = 2, 4, 7 and 10 in all four styles side by side. This covers the smallest legal divisor, a power of two, where the carry preload is a mid value and the sign-bit width grows, and 2^k−1, where the carry preload is 1.

Edges spaced one cycle apart stress the edge detector. A design that counted levels rather than edges, or that let the pulse stretch, would fire early or stay high a second cycle. A long held-high input catches a design that recounts a level.

A reset in the middle of a group exposes a style that reloads the wrong initial value, because its first pulse would then arrive after more or fewer than N edges. A mismatch between styles on any cycle exposes an off-by-one in a single terminal test.

// File: rtl/pdiv_pkg.sv
package pdiv_pkg;

    typedef enum logic [1:0] {
        STY_UP_CMP = 2'd0,
        STY_DN_CMP = 2'd1,
        STY_SIGN   = 2'd2,
        STY_CARRY  = 2'd3
    } count_style_e;

    typedef struct packed {
        logic meta;
        logic sync;
        logic prev;
    } sync_state_t;

    typedef struct packed {
        logic pulse;
    } out_state_t;

endpackage

// File: rtl/pdiv_edge_sync.sv
module pdiv_edge_sync
    import pdiv_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);

    sync_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = async_in;
        st_d.sync = st_q.meta;
        st_d.prev = st_q.sync;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Single-cycle strobe when the synchronised level goes 0 -> 1
    assign rise = st_q.sync & ~st_q.prev;

endmodule

// File: rtl/pdiv_counter.sv
module pdiv_counter
    import pdiv_pkg::*;
#(
    parameter int DIVISOR = 10,
    parameter int STYLE   = 0
) (
    input  logic clk,
    input  logic rst,
    input  logic step,
    output logic hit
);

    localparam int K  = $clog2(DIVISOR + 1);
    localparam int CW = (STYLE == int'(STY_SIGN)) ? K + 1 : K;

    function automatic logic [CW-1:0] start_value();
        logic [CW:0] full;
        full = '0;
        case (STYLE)
            int'(STY_UP_CMP): full = '0;
            int'(STY_DN_CMP): full = (CW+1)'(DIVISOR);
            int'(STY_SIGN):   full = (CW+1)'(DIVISOR - 1);
            default:          full = (CW+1)'((64'd1 << K) - 64'(DIVISOR));
        endcase
        return full[CW-1:0];
    endfunction

    localparam logic [CW-1:0] INIT  = start_value();
    localparam logic [CW-1:0] LIMIT = CW'(DIVISOR);

    logic [CW-1:0] cnt_d, cnt_q;
    logic          hit_c;

    if (DIVISOR < 2) begin : g_bad_divisor
        $fatal(1, "pdiv_counter: DIVISOR must be at least 2");
    end

    if (STYLE == int'(STY_UP_CMP)) begin : g_up_cmp
        logic [CW-1:0] nxt;
        always_comb begin
            nxt   = cnt_q + 1'b1;
            cnt_d = cnt_q;
            hit_c = 1'b0;
            if (step) begin
                if (nxt == LIMIT) begin
                    cnt_d = INIT;
                    hit_c = 1'b1;
                end else begin
                    cnt_d = nxt;
                end
            end
        end
    end else if (STYLE == int'(STY_DN_CMP)) begin : g_dn_cmp
        logic [CW-1:0] nxt;
        always_comb begin
            nxt   = cnt_q - 1'b1;
            cnt_d = cnt_q;
            hit_c = 1'b0;
            if (step) begin
                if (nxt == '0) begin
                    cnt_d = INIT;
                    hit_c = 1'b1;
                end else begin
                    cnt_d = nxt;
                end
            end
        end
    end else if (STYLE == int'(STY_SIGN)) begin : g_sign
        logic [CW-1:0] nxt;
        always_comb begin
            nxt   = cnt_q - 1'b1;
            cnt_d = cnt_q;
            hit_c = 1'b0;
            if (step) begin
                if (nxt[CW-1]) begin
                    cnt_d = INIT;
                    hit_c = 1'b1;
                end else begin
                    cnt_d = nxt;
                end
            end
        end
    end else if (STYLE == int'(STY_CARRY)) begin : g_carry
        logic [CW:0] sum;
        always_comb begin
            sum   = {1'b0, cnt_q} + 1'b1;
            cnt_d = cnt_q;
            hit_c = 1'b0;
            if (step) begin
                if (sum[CW]) begin
                    cnt_d = INIT;
                    hit_c = 1'b1;
                end else begin
                    cnt_d = sum[CW-1:0];
                end
            end
        end
    end else begin : g_bad_style
        $fatal(1, "pdiv_counter: unknown STYLE value");
        always_comb begin
            cnt_d = cnt_q;
            hit_c = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= INIT;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign hit = hit_c;

endmodule

// File: rtl/pulse_rate_div.sv
module pulse_rate_div
    import pdiv_pkg::*;
#(
    parameter int DIVISOR = 10,
    parameter int STYLE   = 0
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_in,
    output logic pulse_out
);

    logic       edge_seen;
    logic       term_hit;
    out_state_t os_d, os_q;

    pdiv_edge_sync i_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (pin_in),
        .rise     (edge_seen)
    );

    pdiv_counter #(
        .DIVISOR (DIVISOR),
        .STYLE   (STYLE)
    ) i_count (
        .clk  (clk),
        .rst  (rst),
        .step (edge_seen),
        .hit  (term_hit)
    );

    always_comb begin
        os_d       = os_q;
        os_d.pulse = term_hit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            os_q <= '0;
        end else begin
            os_q <= os_d;
        end
    end

    assign pulse_out = os_q.pulse;

endmodule

// File: rtl/pulse_rate_div_chk.sv
module pulse_rate_div_chk #(
    parameter int DIVISOR = 10
) (
    input logic clk,
    input logic rst,
    input logic edge_det,
    input logic pulse_q
);

    // Style-independent tally of steps since the last terminal event
    int unsigned seen_q;
    logic        last_step;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q <= 0;
        end else if (edge_det) begin
            seen_q <= (seen_q == DIVISOR - 1) ? 0 : seen_q + 1;
        end
    end

    assign last_step = edge_det && (seen_q == DIVISOR - 1);

    p_one_wide_r2: assert property (@(posedge clk) disable iff (rst)
        pulse_q |=> !pulse_q);

    p_after_step_r1: assert property (@(posedge clk) disable iff (rst)
        pulse_q |-> $past(edge_det));

    p_fires_on_nth_r3: assert property (@(posedge clk) disable iff (rst)
        last_step |=> pulse_q);

    p_no_stray_r3: assert property (@(posedge clk) disable iff (rst)
        !last_step |=> !pulse_q);

    p_step_isolated_r10: assert property (@(posedge clk) disable iff (rst)
        edge_det |=> !edge_det);

    p_reset_clear_r9: assert property (@(posedge clk)
        rst |=> !pulse_q);

endmodule

bind pulse_rate_div pulse_rate_div_chk #(.DIVISOR(DIVISOR)) i_chk (
    .clk      (clk),
    .rst      (rst),
    .edge_det (edge_seen),
    .pulse_q  (pulse_out)
);

// File: tb/test_pulse_rate_div.sv
`timescale 1ns/1ps
module test_pulse_rate_div;

    localparam int NN = 4;
    localparam int NS = 4;

    function automatic int n_of(input int i);
        case (i)
            0:       return 2;
            1:       return 4;
            2:       return 7;
            default: return 10;
        endcase
    endfunction

    function automatic string sname(input int s);
        case (s)
            0:       return "R4 up-compare";
            1:       return "R5 down-compare";
            2:       return "R6 sign-bit";
            default: return "R7 carry";
        endcase
    endfunction

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pin = 1'b0;
    logic [NN*NS-1:0] pout;
    logic [NN*NS-1:0] last_out = '0;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    int ecnt   [NN];
    logic sr   [NN][3];
    logic pin_prev = 1'b0;

    always #2.5 clk = ~clk;

    for (genvar i = 0; i < NN; i++) begin : g_n
        for (genvar j = 0; j < NS; j++) begin : g_s
            pulse_rate_div #(
                .DIVISOR (n_of(i)),
                .STYLE   (j)
            ) i_pulse_rate_div (
                .clk       (clk),
                .rst       (rst),
                .pin_in    (pin),
                .pulse_out (pout[i*NS+j])
            );
        end
    end

    task automatic step(input logic p, input logic r, input string tag);
        @(negedge clk);
        cyc++;
        for (int i = 0; i < NN; i++) begin
            for (int j = 0; j < NS; j++) begin
                checks++;
                if (pout[i*NS+j] !== sr[i][2]) begin
                    errors++;
                    $display("FAIL %s %s N=%0d cycle %0d: actual %b expected %b",
                             tag, sname(j), n_of(i), cyc, pout[i*NS+j], sr[i][2]);
                end
            end
            checks++;
            if (pout[i*NS +: NS] !== {NS{pout[i*NS]}}) begin
                errors++;
                $display("FAIL R8 N=%0d cycle %0d: actual %b expected all equal",
                         n_of(i), cyc, pout[i*NS +: NS]);
            end
        end
        for (int k = 0; k < NN*NS; k++) begin
            if (pout[k]) begin
                checks++;
                if (last_out[k]) begin
                    errors++;
                    $display("FAIL R2 output %0d cycle %0d: actual 11 expected 10", k, cyc);
                end
            end
        end
        last_out = pout;
        rst = r;
        pin = r ? 1'b0 : p;
        if (r) begin
            for (int i = 0; i < NN; i++) begin
                ecnt[i] = 0;
                sr[i][0] = 1'b0; sr[i][1] = 1'b0; sr[i][2] = 1'b0;
            end
            pin_prev = 1'b0;
        end else begin
            for (int i = 0; i < NN; i++) begin
                logic fire;
                fire = 1'b0;
                if (p && !pin_prev) begin
                    if (ecnt[i] + 1 == n_of(i)) begin
                        ecnt[i] = 0;
                        fire = 1'b1;
                    end else begin
                        ecnt[i] = ecnt[i] + 1;
                    end
                end
                sr[i][2] = sr[i][1];
                sr[i][1] = sr[i][0];
                sr[i][0] = fire;
            end
            pin_prev = p;
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < NN; i++) begin
            ecnt[i] = 0;
            sr[i][0] = 1'b0; sr[i][1] = 1'b0; sr[i][2] = 1'b0;
        end
        void'($urandom(32'd20240611));
        // R9: reset state
        for (int c = 0; c < 4; c++) step(1'b0, 1'b1, "R9");
        for (int c = 0; c < 3; c++) step(1'b0, 1'b0, "R9");
        // R1: densest edge spacing, exact pulse cycle
        for (int c = 0; c < 12; c++) begin
            step(1'b1, 1'b0, "R1");
            step(1'b0, 1'b0, "R1");
        end
        for (int c = 0; c < 5; c++) step(1'b0, 1'b0, "R1");
        // R10: long high level counts once
        for (int c = 0; c < 25; c++) step(1'b1, 1'b0, "R10");
        for (int c = 0; c < 25; c++) step(1'b0, 1'b0, "R10");
        for (int c = 0; c < 6; c++) begin
            for (int h = 0; h < 9; h++) step(1'b1, 1'b0, "R10");
            step(1'b0, 1'b0, "R10");
        end
        // R3: random spacing
        for (int e = 0; e < 3000; e++) begin
            int hi, lo;
            hi = $urandom_range(1, 4);
            lo = $urandom_range(1, 4);
            for (int h = 0; h < hi; h++) step(1'b1, 1'b0, "R3");
            for (int l = 0; l < lo; l++) step(1'b0, 1'b0, "R3");
        end
        // R9: reset in the middle of a group
        for (int c = 0; c < 3; c++) begin
            step(1'b1, 1'b0, "R9");
            step(1'b0, 1'b0, "R9");
        end
        for (int c = 0; c < 2; c++) step(1'b0, 1'b1, "R9");
        for (int e = 0; e < 500; e++) begin
            int hi, lo;
            hi = $urandom_range(1, 3);
            lo = $urandom_range(1, 5);
            for (int h = 0; h < hi; h++) step(1'b1, 1'b0, "R9");
            for (int l = 0; l < lo; l++) step(1'b0, 1'b0, "R9");
        end
        for (int c = 0; c < 5; c++) step(1'b0, 1'b0, "R3");
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R3 watchdog: actual %0d cycles expected completion", cyc);
        finish_run();
    end

endmodule